// File: doc/BRIEF.md
# Intermittent CPU Clock Throttle

This block sits between a free-running peripheral clock and the clock input of a CPU core. It lowers CPU power by inserting a halt period after every instruction that touches a register, on-chip memory, I/O, a peripheral or the external bus. During a halt the CPU receives no clock pulses, but the peripheral clock keeps running. Peripherals and the external bus stay on the ungated clock, so they are unaffected. The CPU therefore slows down by a predictable amount while everything around it keeps full speed.

The CPU reports each completed instruction with a one-cycle strobe, together with a flag that says whether the instruction accessed the bus. When throttling is enabled and the 2-bit length select is non-zero, the block starts a halt:

- The CPU clock stays low for exactly the selected number of peripheral-clock cycles.
- A hold output stays asserted for the whole halt, so the next internal bus cycle cannot start.
- A down-counter exposes the number of halt cycles still to run.

The gated clock comes from a latch-based enable that is updated only while the peripheral clock is low. This keeps the CPU clock free of runt pulses.

Top module: `cpu_clk_throttle`

## Requirements
- R1: While reset is asserted, and after it is released, the hold output is 0, the remaining-cycle counter is 0 and the CPU clock enable is 1.
- R2: The length select is encoded as 01 = 8 cycles, 10 = 16 cycles and 11 = 32 cycles. A qualifying strobe sampled on a clock edge makes the hold output high for exactly that many following cycles, starting right after that edge.
- R3: When the select is 00, a qualifying strobe produces no halt.
- R4: A strobe sampled with the access flag low produces no halt.
- R5: A strobe sampled while the throttle enable is low produces no halt.
- R6: During a halt, the counter reads L right after the starting edge and drops by one on each edge. The hold output is high exactly while the counter is non-zero.
- R7: Each qualifying instruction removes exactly L rising edges from the CPU clock. Over any window of whole halts, the CPU pulse count equals the peripheral cycle count minus the access count times L.
- R8: A change of the select during a halt does not alter that halt's length. The next halt uses the new value.
- R9: A strobe that arrives while a halt is running is ignored and does not extend the halt.
- R10: The CPU clock output is never high while the peripheral clock is low, and its enable changes only during the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| thr_en_i | input | 1 | Throttle mode enable |
| len_sel_i | input | 2 | Halt length select (00 none, 01 8, 10 16, 11 32) |
| instr_done_i | input | 1 | One-cycle instruction-complete strobe |
| instr_acc_i | input | 1 | The completing instruction accessed the bus |
| cpu_clk_o | output | 1 | Gated CPU clock |
| cpu_clk_en_o | output | 1 | Latched enable used for the gated clock |
| bus_hold_o | output | 1 | Holds off the internal bus cycle during a halt |
| halt_left_o | output | 6 | Halt cycles still to run |

## Verification
The bench measures each halt edge by edge, both on the hold output and by counting CPU clock pulses in a fixed window. An off-by-one in the down-counter, or in the half-cycle latch, shows up directly as L±1 suppressed pulses. It changes the select in the middle of a halt; a design that decoded the select live would stretch that halt to 32 cycles. It fires a second strobe during a halt; a design that reloaded the counter would stretch the halt. It also checks that strobes without the access flag, with the mode disabled, or with select 00 start no halt, since a wrong qualifier would cost CPU cycles on every instruction. A mixed instruction sequence confirms that the total CPU pulse count matches the peripheral cycles minus the accesses times L. A negative-phase monitor catches any pulse on the gated clock while the peripheral clock is low.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_SHORT = 2'b01,
    SEL_MID = 2'b10,
    SEL_LONG = 2'b11
  } len_sel_e;
endpackage

// File: rtl/thr_rst_sync.sv
module thr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/thr_len_dec.sv
module thr_len_dec #(
  parameter int unsigned LEN_SHORT = 8,
  parameter int unsigned LEN_MID   = 16,
  parameter int unsigned LEN_LONG  = 32,
  parameter int unsigned CNT_W     = $clog2(LEN_LONG + 1)
) (
  input  thr_pkg::len_sel_e sel_i,
  output logic [CNT_W-1:0]  len_o
);
  import thr_pkg::*;

  always_comb begin
    unique case (sel_i)
      SEL_SHORT: len_o = CNT_W'(LEN_SHORT);
      SEL_MID:   len_o = CNT_W'(LEN_MID);
      SEL_LONG:  len_o = CNT_W'(LEN_LONG);
      default:   len_o = '0;
    endcase
  end
endmodule

// File: rtl/thr_halt_seq.sv
module thr_halt_seq #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_en_i,
  input  logic             instr_done_i,
  input  logic             instr_acc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             hold_o,
  output logic [CNT_W-1:0] left_o
);
  logic [CNT_W-1:0] left_q, left_d;
  logic             hold_q, hold_d;
  logic             idle, trig;

  assign idle = (left_q == '0);
  assign trig = idle && thr_en_i && instr_done_i && instr_acc_i && (len_i != '0);

  always_comb begin
    left_d = left_q;
    if (trig)       left_d = len_i;
    else if (!idle) left_d = left_q - CNT_W'(1);
    hold_d = trig || (left_q > CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      hold_q <= 1'b0;
    end else begin
      left_q <= left_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;
  assign left_o = left_q;

  a_r2_load_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && thr_en_i && instr_done_i && instr_acc_i && len_i != '0) |=> (left_q == $past(len_i)));
  a_r3_zero_len_no_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && len_i == '0) |=> (left_q == '0));
  a_r4_no_access_no_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !instr_acc_i) |=> (left_q == '0));
  a_r5_disabled_no_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !thr_en_i) |=> (left_q == '0));
  a_r6_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle) |=> (left_q == $past(left_q) - CNT_W'(1)));
  a_r6_hold_tracks_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q == (left_q != '0));
endmodule

// File: rtl/thr_clk_gate.sv
module thr_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic en_lat_o,
  output logic gclk_o
);
  logic en_lat;

  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign en_lat_o = en_lat;
  assign gclk_o   = clk_i & en_lat;

  always_comb begin
    if (!clk_i) a_r10_no_low_phase_pulse: assert (!gclk_o);
  end
endmodule

// File: rtl/cpu_clk_throttle.sv
module cpu_clk_throttle #(
  parameter int unsigned LEN_SHORT = 8,
  parameter int unsigned LEN_MID   = 16,
  parameter int unsigned LEN_LONG  = 32,
  parameter int unsigned CNT_W     = $clog2(LEN_LONG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_en_i,
  input  logic [1:0]       len_sel_i,
  input  logic             instr_done_i,
  input  logic             instr_acc_i,
  output logic             cpu_clk_o,
  output logic             cpu_clk_en_o,
  output logic             bus_hold_o,
  output logic [CNT_W-1:0] halt_left_o
);
  import thr_pkg::*;

  logic             rst_sync_n;
  logic [CNT_W-1:0] len;
  logic             hold;

  thr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  thr_len_dec #(
    .LEN_SHORT(LEN_SHORT), .LEN_MID(LEN_MID), .LEN_LONG(LEN_LONG), .CNT_W(CNT_W)
  ) u_dec (
    .sel_i(len_sel_e'(len_sel_i)), .len_o(len)
  );

  thr_halt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .thr_en_i(thr_en_i),
    .instr_done_i(instr_done_i), .instr_acc_i(instr_acc_i),
    .len_i(len), .hold_o(hold), .left_o(halt_left_o)
  );

  thr_clk_gate u_gate (
    .clk_i(clk_i), .en_i(!hold), .en_lat_o(cpu_clk_en_o), .gclk_o(cpu_clk_o)
  );

  assign bus_hold_o = hold;

  // R7: at every peripheral edge the latched enable is the inverse of the hold
  a_r7_gate_follows_hold: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cpu_clk_en_o == !bus_hold_o);
  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_sync_n) |-> (!bus_hold_o && halt_left_o == '0));
endmodule

// File: tb/cpu_clk_throttle_test.sv
`timescale 1ns/1ps
module cpu_clk_throttle_test;
  logic       clk_i = 1'b0;
  logic       rst_ni, thr_en_i, instr_done_i, instr_acc_i;
  logic [1:0] len_sel_i;
  logic       cpu_clk_o, cpu_clk_en_o, bus_hold_o;
  logic [5:0] halt_left_o;

  int checks = 0;
  int fails  = 0;
  int glitches = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cpu_clk_throttle uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .thr_en_i(thr_en_i), .len_sel_i(len_sel_i),
    .instr_done_i(instr_done_i), .instr_acc_i(instr_acc_i), .cpu_clk_o(cpu_clk_o),
    .cpu_clk_en_o(cpu_clk_en_o), .bus_hold_o(bus_hold_o), .halt_left_o(halt_left_o)
  );

  // R10 monitor: gated clock must be low in the middle of every low phase
  always @(negedge clk_i) begin
    #1;
    if (cpu_clk_o === 1'b1) glitches++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] s);
    case (s)
      2'b01: return 8;
      2'b10: return 16;
      2'b11: return 32;
      default: return 0;
    endcase
  endfunction

  // Drive one instruction strobe, observe W edges from the sampling edge.
  // Optional mid-halt select change (at chg_at) or extra strobe (at rs_at).
  task automatic run_instr(input bit acc, input int win, input int chg_at,
                           input logic [1:0] chg_sel, input int rs_at,
                           output int holds, output int pulses, output int first_left);
    @(negedge clk_i);
    instr_done_i = 1'b1;
    instr_acc_i  = acc;
    holds = 0; pulses = 0; first_left = -1;
    for (int i = 0; i < win; i++) begin
      @(posedge clk_i);
      #1;
      if (i == 0) first_left = halt_left_o;
      if (i == 0 || i == rs_at + 1) begin instr_done_i = 1'b0; instr_acc_i = 1'b0; end
      if (i == rs_at) begin instr_done_i = 1'b1; instr_acc_i = 1'b1; end
      if (i == chg_at) len_sel_i = chg_sel;
      if (cpu_clk_o) pulses++;
      if (bus_hold_o) holds++;
      if ((halt_left_o != 0) != bus_hold_o) chk(0, "R6 hold vs counter", bus_hold_o, halt_left_o != 0);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; thr_en_i = 1'b0; len_sel_i = 2'b00;
    instr_done_i = 1'b0; instr_acc_i = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(bus_hold_o == 0, "R1 hold in reset", bus_hold_o, 0);
    chk(halt_left_o == 0, "R1 counter in reset", halt_left_o, 0);
    chk(cpu_clk_en_o == 1, "R1 enable in reset", cpu_clk_en_o, 1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    #1;
    chk(bus_hold_o == 0 && halt_left_o == 0 && cpu_clk_en_o == 1, "R1 after release", halt_left_o, 0);
  endtask

  task automatic t_lengths();
    int h, p, f;
    thr_en_i = 1'b1;
    for (int s = 1; s < 4; s++) begin
      len_sel_i = 2'(s);
      run_instr(1, 40, -5, 2'b00, -5, h, p, f);
      chk(h == len_of(2'(s)), "R2 hold length", h, len_of(2'(s)));
      chk(f == len_of(2'(s)), "R6 counter start", f, len_of(2'(s)));
      chk(p == 40 - len_of(2'(s)), "R7 suppressed pulses", p, 40 - len_of(2'(s)));
    end
  endtask

  task automatic t_no_halt();
    int h, p, f;
    len_sel_i = 2'b00;
    run_instr(1, 10, -5, 2'b00, -5, h, p, f);
    chk(h == 0 && p == 10, "R3 select 00", p, 10);
    len_sel_i = 2'b01;
    run_instr(0, 10, -5, 2'b00, -5, h, p, f);
    chk(h == 0 && p == 10, "R4 no access flag", p, 10);
    thr_en_i = 1'b0;
    run_instr(1, 10, -5, 2'b00, -5, h, p, f);
    chk(h == 0 && p == 10, "R5 mode disabled", p, 10);
    thr_en_i = 1'b1;
  endtask

  task automatic t_sel_change();
    int h, p, f;
    len_sel_i = 2'b01;
    run_instr(1, 40, 2, 2'b11, -5, h, p, f);
    chk(h == 8, "R8 mid-halt change ignored", h, 8);
    run_instr(1, 40, -5, 2'b00, -5, h, p, f);
    chk(h == 32, "R8 next halt uses new select", h, 32);
  endtask

  task automatic t_retrigger();
    int h, p, f;
    len_sel_i = 2'b10;
    run_instr(1, 30, -5, 2'b00, 3, h, p, f);
    chk(h == 16, "R9 strobe in halt ignored", h, 16);
    chk(p == 30 - 16, "R9 pulses unchanged", p, 14);
  endtask

  task automatic t_program();
    int h, p, f, tot_p, tot_c, acc_n;
    bit pat[8] = '{1, 0, 1, 1, 0, 0, 1, 0};
    len_sel_i = 2'b01;
    tot_p = 0; tot_c = 0; acc_n = 0;
    foreach (pat[k]) begin
      run_instr(pat[k], 12, -5, 2'b00, -5, h, p, f);
      tot_p += p; tot_c += 12; acc_n += pat[k];
    end
    chk(tot_p == tot_c - acc_n * 8, "R7 program total", tot_p, tot_c - acc_n * 8);
  endtask

  initial begin
    t_reset();
    t_lengths();
    t_no_halt();
    t_sel_change();
    t_retrigger();
    t_program();
    chk(glitches == 0, "R10 low-phase pulses", glitches, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule